// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This block applies one of the sixteen possible two-input Boolean functions to every bit position of two operand words at once. Bit i of the result depends only on bit i of each operand and on a shared 4-bit function code. The code is the truth table of the chosen function: the operand bit pair picks one of the four code bits, and that bit becomes the result bit. Any two-input function is therefore reached with no decoding. The code is simply the function's number in the usual enumeration of two-variable functions.

The datapath is built from identical one-bit slices, one for each operand bit. Each slice is a two-level multiplexer steered by its own operand bits. The slice outputs are captured in a result register on each rising clock edge, so a result appears one cycle after its operands and code are presented. There is no carry, no arithmetic and no flag output.

Top module: `bitwise_fn_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `f_q` is all zeros after that edge.
- R2: The value on `f_q` after a rising edge with `rst` low is computed from the `a`, `b` and `code` values sampled at that edge, with a latency of exactly one cycle.
- R3: For every bit i, `f_q[i]` equals `code[2*a[i] + b[i]]`. Pair (a,b)=00 selects `code[0]`, 01 selects `code[1]`, 10 selects `code[2]` and 11 selects `code[3]`.
- R4: Code 0 (4'b0000) gives all zeros for any operands.
- R5: Code 15 (4'b1111) gives all ones for any operands.
- R6: Code 8 (4'b1000) gives the bitwise AND of `a` and `b`.
- R7: Code 14 (4'b1110) gives the bitwise OR of `a` and `b`.
- R8: Code 6 (4'b0110) gives the bitwise XOR of `a` and `b`.
- R9: Code 12 (4'b1100) passes `a` unchanged, and code 10 (4'b1010) passes `b` unchanged.
- R10: Code 3 (4'b0011) gives the complement of `a`, and code 5 (4'b0101) gives the complement of `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| code | input | 4 | Function code, equal to the function's truth table |
| f_q | output | WIDTH | Registered bitwise result |

## Verification
A fault in one slice would show up only in that bit of `f_q`. It would appear one cycle after the operand pair that exposes it. It could also stay hidden for codes whose truth-table entries happen to match. For this reason every code is applied with many random operand words, and every bit position sees all four pair values. A wrong index order inside the slice would swap the roles of `a` and `b`. Codes such as 2, 4, 10 and 12 differ only in that order, so such a fault shows up on the first cycle those codes are used with `a` different from `b`. A fault in the result register or the reset shows up on the first cycle of or after reset.

// File: rtl/bitwise_fn_pkg.sv
package bitwise_fn_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] fn_code_t;

  localparam fn_code_t FN_ZERO  = 4'd0;
  localparam fn_code_t FN_NOT_A = 4'd3;
  localparam fn_code_t FN_NOT_B = 4'd5;
  localparam fn_code_t FN_XOR   = 4'd6;
  localparam fn_code_t FN_AND   = 4'd8;
  localparam fn_code_t FN_PASSB = 4'd10;
  localparam fn_code_t FN_PASSA = 4'd12;
  localparam fn_code_t FN_OR    = 4'd14;
  localparam fn_code_t FN_ONE   = 4'd15;

endpackage

// File: rtl/bitwise_fn_slice.sv
module bitwise_fn_slice
  import bitwise_fn_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  fn_code_t code,
  output logic     f_bit
);

  // First level picks by b: low pair (a=0) and high pair (a=1).
  logic lo_sel;
  logic hi_sel;

  always_comb begin
    lo_sel = b_bit ? code[1] : code[0];
    hi_sel = b_bit ? code[3] : code[2];
    f_bit  = a_bit ? hi_sel : lo_sel;
  end

endmodule

// File: rtl/bitwise_fn_array.sv
module bitwise_fn_array
  import bitwise_fn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  fn_code_t         code,
  output logic [WIDTH-1:0] f
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bitwise_fn_slice u_slice (
      .a_bit (a[i]),
      .b_bit (b[i]),
      .code  (code),
      .f_bit (f[i])
    );
  end

endmodule

// File: rtl/bitwise_fn_unit.sv
module bitwise_fn_unit
  import bitwise_fn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       code,
  output logic [WIDTH-1:0] f_q
);

  logic [WIDTH-1:0] f_comb;

  bitwise_fn_array #(.WIDTH(WIDTH)) u_array (
    .a    (a),
    .b    (b),
    .code (code),
    .f    (f_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) f_q <= '0;
    else     f_q <= f_comb;
  end

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (code == FN_ZERO) |=> (f_q == '0));

  p_one_r5: assert property (@(posedge clk) disable iff (rst)
    (code == FN_ONE) |=> (f_q == '1));

  p_and_r6: assert property (@(posedge clk) disable iff (rst)
    (code == FN_AND) |=> (f_q == ($past(a) & $past(b))));

  p_or_r7: assert property (@(posedge clk) disable iff (rst)
    (code == FN_OR) |=> (f_q == ($past(a) | $past(b))));

  p_xor_r8: assert property (@(posedge clk) disable iff (rst)
    (code == FN_XOR) |=> (f_q == ($past(a) ^ $past(b))));

  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (code == FN_PASSA) |=> (f_q == $past(a)));

  p_inv_r10: assert property (@(posedge clk) disable iff (rst)
    (code == FN_NOT_B) |=> (f_q == ~$past(b)));

endmodule

// File: tb/bitwise_fn_unit_test.sv
module bitwise_fn_unit_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   code = 4'd15;
  logic [W-1:0] f_q;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit mon_on = 0;

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  exp_t pend[$];

  always #4 clk = ~clk;

  bitwise_fn_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .code(code), .f_q(f_q)
  );

  function automatic logic [W-1:0] ref_fn(logic [3:0] c, logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = c[{x[i], y[i]}];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: applies one item at a falling edge and queues its expectation.
  task automatic drive(logic [3:0] c, logic [W-1:0] x, logic [W-1:0] y,
                       string tag, logic [W-1:0] exp);
    exp_t e;
    @(negedge clk);
    code = c; a = x; b = y;
    e.val = exp; e.tag = tag;
    pend.push_back(e);
  endtask

  // Monitor: the result is registered on the following rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && pend.size() > 0) begin
        exp_t e;
        e = pend.pop_front();
        check(e.tag, f_q, e.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    a = 8'hA5; b = 8'h3C;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", f_q, '0);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1;

    // R2: back-to-back items, each seen exactly one cycle later
    drive(4'd8,  8'hF0, 8'hAA, "R2 latency",  8'hA0);
    drive(4'd14, 8'hF0, 8'hAA, "R2 latency",  8'hFA);
    // R4, R5 with hostile operands
    drive(4'd0,  8'hFF, 8'hFF, "R4 zero",     8'h00);
    drive(4'd15, 8'h00, 8'h00, "R5 one",      8'hFF);
    drive(4'd6,  8'hCC, 8'hAA, "R8 xor",      8'h66);
    drive(4'd12, 8'h5A, 8'hC3, "R9 pass a",   8'h5A);
    drive(4'd10, 8'h5A, 8'hC3, "R9 pass b",   8'hC3);
    drive(4'd3,  8'h5A, 8'hC3, "R10 not a",   8'hA5);
    drive(4'd5,  8'h5A, 8'hC3, "R10 not b",   8'h3C);
    // R3: index order, pair 10 vs 01 (code 4 = a&~b, code 2 = ~a&b)
    drive(4'd4,  8'hF0, 8'h0F, "R3 order",    8'hF0);
    drive(4'd2,  8'hF0, 8'h0F, "R3 order",    8'h0F);

    for (int k = 0; k < 20; k++) begin
      x = W'($urandom); y = W'($urandom);
      drive(4'd8,  x, y, "R6 and", x & y);
      drive(4'd14, x, y, "R7 or",  x | y);
      drive(4'd6,  x, y, "R8 xor", x ^ y);
    end

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 16; k++) begin
        x = W'($urandom); y = W'($urandom);
        drive(4'(c), x, y, "R3 sweep", ref_fn(4'(c), x, y));
      end
    end

    // R1 again: reset mid-run clears the held result
    drive(4'd15, 8'h00, 8'h00, "R5 one", 8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset", f_q, '0);
    pend.delete();
    repeat (2) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule